// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs one conversion at a time for an analog front end that multiplexes ten inputs. Inputs 0 to 7 are the ordinary differential channels. Input 8 is the +10 V reference and input 9 is the 0 V reference. A host writes one 16-bit control word. That word carries an enable mask for the inputs, the number of the input to read, a flag that asks for a settling delay, and a start bit. The block drives the mux select and enable lines from the latched word. It waits out the optional settling delay and then asks the converter for a sample through a request/ready handshake.

When the sample returns, the block stores it with bit 15 inverted, so the data register holds offset-binary code. It then sets a done flag in an interrupt status register, which the host clears by writing a one. An interrupt enable register masks the interrupt line. Every sample needs a new control write with the start bit set. A start that names an input whose enable bit is clear finishes at once with a zero result.

Top module: `mcs_sequencer`

## Requirements
- R1: The control word is written at address 0. Bit 0 is start, bits 4:1 are the read-channel number, bits 14:5 are the enable mask (bit 5+n enables input n) and bit 15 is the settle flag. A control write accepted while idle drives `mux_sel` and `mux_en` from bits 4:1 and 14:5 from the next clock edge.
- R2: Without the settle flag, `conv_req` is high from the edge that takes a start write and stays high until the edge where `conv_ready` is sampled high.
- R3: With the settle flag, `conv_req` rises exactly SETTLE_CYCLES clock cycles later than it would without the flag.
- R4: At the edge where `conv_req` and `conv_ready` are both high, `result` takes `conv_data` with bit 15 inverted and `busy` falls.
- R5: Completion sets bit 2 of `irq_status`. All other bits of `irq_status` always read zero.
- R6: A write at address 2 with bit 2 set clears the done flag. The same write with bit 2 clear leaves the flag unchanged. If a completion and a clearing write fall on the same edge, the flag stays set.
- R7: `irq` is high exactly when the done flag is set and bit 2 of the interrupt enable register (address 1) is set.
- R8: While `busy` is high, a control write is ignored. `mux_sel` and `mux_en` do not change, and no further conversion follows the current one.
- R9: A start whose read channel is above 9, or whose enable bit is clear, raises no `conv_req` and never sets `busy`. `result` becomes 0x0000 and the done flag is set on the next edge.
- R10: A control write with the start bit clear updates `mux_sel` and `mux_en` but starts nothing and leaves the done flag unchanged.
- R11: After reset `mux_sel`, `mux_en`, `result`, `irq_status`, `conv_req`, `busy` and `irq` are all zero.
- R12: Reference inputs 8 and 9 convert through the same sequence as the ordinary inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address: 0 control, 1 interrupt enable, 2 interrupt status |
| host_wdata | input | 16 | Host write data |
| mux_sel | output | 4 | Input selected for reading |
| mux_en | output | 10 | Input enable mask |
| conv_req | output | 1 | Converter sample request |
| conv_ready | input | 1 | Converter sample valid |
| conv_data | input | 16 | Converter sample, two's complement |
| result | output | 16 | Last result, offset binary |
| busy | output | 1 | Conversion in progress |
| irq_status | output | 16 | Interrupt status, bit 2 done |
| irq | output | 1 | Masked interrupt |

## Verification
The bench counts the cycles from the start write to the rise of `conv_req`, both with and without the settle flag. A timer that is off by one moves that edge, and the bench catches it. It sends a start write while a conversion runs. A design that accepted it would move the mux select or begin a second request. It also starts inputs that are disabled or out of range. A design that ran them would raise `conv_req` or keep the old result instead of zero.

The bench lines up a clearing write with a completion on the same edge. A design whose clear wins would lose that completion. It also toggles the interrupt enable, so a design that let `irq` through without the mask would show up.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int NUM_CH   = 10;
    localparam int SEL_W    = 4;
    localparam int WORD_W   = 16;
    localparam int DONE_BIT = 2;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_IEN   = 2'd1;
    localparam logic [1:0] ADDR_ISTAT = 2'd2;

    // Field order is fixed by the host's view of the control word.
    typedef struct packed {
        logic              settle;
        logic [NUM_CH-1:0] en_mask;
        logic [SEL_W-1:0]  sel;
        logic              go;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_t;

    function automatic logic read_enabled(input ctrl_word_t c);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(c.sel) == i) ok = c.en_mask[i];
        end
        return ok;
    endfunction

    function automatic logic [WORD_W-1:0] to_offset(input logic [WORD_W-1:0] raw);
        return {~raw[WORD_W-1], raw[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/mcs_settle_timer.sv
module mcs_settle_timer #(
    parameter int CYCLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic fire
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (arm) begin
            running <= 1'b1;
            cnt     <= CW'(CYCLES - 1);
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign fire = running && (cnt == '0);

    // Settle window ends in a single pulse (R3)
    assert_single_fire_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && !arm) |=> !fire);

endmodule

// File: rtl/mcs_conv_fsm.sv
module mcs_conv_fsm
    import mcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_we,
    input  ctrl_word_t          ctrl_in,
    input  logic                settle_fire,
    input  logic                conv_ready,
    input  logic [WORD_W-1:0]   conv_data,
    output logic [SEL_W-1:0]    mux_sel,
    output logic [NUM_CH-1:0]   mux_en,
    output logic                conv_req,
    output logic                busy,
    output logic [WORD_W-1:0]   result,
    output logic                settle_arm,
    output logic                done_set
);
    phase_t phase;
    logic   accept;
    logic   launch;
    logic   chan_ok;

    assign accept  = (phase == PH_IDLE) && ctrl_we;
    assign launch  = accept && ctrl_in.go;
    assign chan_ok = read_enabled(ctrl_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            mux_sel <= '0;
            mux_en  <= '0;
            result  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        mux_sel <= ctrl_in.sel;
                        mux_en  <= ctrl_in.en_mask;
                        if (ctrl_in.go) begin
                            if (chan_ok) phase  <= ctrl_in.settle ? PH_SETTLE : PH_CONV;
                            else         result <= '0;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (settle_fire) phase <= PH_CONV;
                end
                PH_CONV: begin
                    if (conv_ready) begin
                        result <= to_offset(conv_data);
                        phase  <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign conv_req   = (phase == PH_CONV);
    assign busy       = (phase != PH_IDLE);
    assign settle_arm = launch && chan_ok && ctrl_in.settle;
    assign done_set   = (launch && !chan_ok) || (conv_req && conv_ready);

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_we) |=> ($stable(mux_sel) && $stable(mux_en)));

    assert_result_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_ready) |=>
            (!busy && result[WORD_W-1] == !$past(conv_data[WORD_W-1])
                   && result[WORD_W-2:0] == $past(conv_data[WORD_W-2:0])));

    assert_disabled_start_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_we && ctrl_in.go && !read_enabled(ctrl_in)) |=>
            (!busy && result == '0));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_ready) |=> conv_req);

endmodule

// File: rtl/mcs_irq_regs.sv
module mcs_irq_regs
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ien_we,
    input  logic              ien_bit_in,
    input  logic              istat_we,
    input  logic              istat_clr,
    input  logic              done_set,
    output logic [WORD_W-1:0] irq_status,
    output logic              irq
);
    logic ien_bit;
    logic done_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_bit   <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            if (ien_we) ien_bit <= ien_bit_in;
            if (done_set)                   done_flag <= 1'b1;
            else if (istat_we && istat_clr) done_flag <= 1'b0;
        end
    end

    always_comb begin
        irq_status           = '0;
        irq_status[DONE_BIT] = done_flag;
    end

    assign irq = done_flag && ien_bit;

    assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
        done_set |=> irq_status[DONE_BIT]);

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (istat_we && istat_clr && !done_set) |=> !irq_status[DONE_BIT]);

    assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> irq_status[DONE_BIT]);

    assert_status_sparse_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_status) <= 1);

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
    import mcs_pkg::*;
#(
    parameter int SETTLE_CYCLES = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [1:0]            host_addr,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic [SEL_W-1:0]      mux_sel,
    output logic [NUM_CH-1:0]     mux_en,
    output logic                  conv_req,
    input  logic                  conv_ready,
    input  logic [WORD_W-1:0]     conv_data,
    output logic [WORD_W-1:0]     result,
    output logic                  busy,
    output logic [WORD_W-1:0]     irq_status,
    output logic                  irq
);
    logic       ctrl_we;
    logic       ien_we;
    logic       istat_we;
    ctrl_word_t ctrl_in;
    logic       settle_arm;
    logic       settle_fire;
    logic       done_set;

    assign ctrl_we  = host_we && (host_addr == ADDR_CTRL);
    assign ien_we   = host_we && (host_addr == ADDR_IEN);
    assign istat_we = host_we && (host_addr == ADDR_ISTAT);
    assign ctrl_in  = ctrl_word_t'(host_wdata);

    mcs_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .arm  (settle_arm),
        .fire (settle_fire)
    );

    mcs_conv_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctrl_we     (ctrl_we),
        .ctrl_in     (ctrl_in),
        .settle_fire (settle_fire),
        .conv_ready  (conv_ready),
        .conv_data   (conv_data),
        .mux_sel     (mux_sel),
        .mux_en      (mux_en),
        .conv_req    (conv_req),
        .busy        (busy),
        .result      (result),
        .settle_arm  (settle_arm),
        .done_set    (done_set)
    );

    mcs_irq_regs u_irq (
        .clk        (clk),
        .rst        (rst),
        .ien_we     (ien_we),
        .ien_bit_in (host_wdata[DONE_BIT]),
        .istat_we   (istat_we),
        .istat_clr  (host_wdata[DONE_BIT]),
        .done_set   (done_set),
        .irq_status (irq_status),
        .irq        (irq)
    );

endmodule

// File: tb/mcs_sequencer_test.sv
module mcs_sequencer_test;
    localparam int SETTLE = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [3:0]  mux_sel;
    logic [9:0]  mux_en;
    logic        conv_req;
    logic        conv_ready = 1'b0;
    logic [15:0] conv_data = 16'h0;
    logic [15:0] result;
    logic        busy;
    logic [15:0] irq_status;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mcs_sequencer #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .mux_sel(mux_sel), .mux_en(mux_en),
        .conv_req(conv_req), .conv_ready(conv_ready), .conv_data(conv_data),
        .result(result), .busy(busy), .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cword(input logic settle, input logic [9:0] en,
                                          input logic [3:0] sel, input logic go);
        return {settle, en, sel, go};
    endfunction

    function automatic logic [15:0] offset_of(input logic [15:0] raw);
        return raw ^ 16'h8000;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run_conv(input logic settle, input logic [9:0] en, input logic [3:0] sel,
                            input logic [15:0] data, input int lat, input string tag);
        int k;
        wr(2'd0, cword(settle, en, sel, 1'b1));
        chk({tag, " R1 mux_sel"}, 32'(mux_sel), 32'(sel));
        chk({tag, " R1 mux_en"}, 32'(mux_en), 32'(en));
        k = 0;
        while (!conv_req && k < 50) begin
            @(negedge clk);
            k++;
        end
        if (settle) chk({tag, " R3 settle delay"}, 32'(k), 32'(SETTLE));
        else        chk({tag, " R2 req latency"}, 32'(k), 32'd0);
        chk({tag, " R2 busy"}, 32'(busy), 32'd1);
        repeat (lat) @(negedge clk);
        chk({tag, " R2 req held"}, 32'(conv_req), 32'd1);
        conv_ready = 1'b1; conv_data = data;
        @(negedge clk);
        conv_ready = 1'b0;
        chk({tag, " R4 result"}, 32'(result), 32'(offset_of(data)));
        chk({tag, " R4 busy low"}, 32'(busy), 32'd0);
        chk({tag, " R5 done"}, 32'(irq_status), 32'h0004);
        wr(2'd2, 16'h0004);
        chk({tag, " R6 cleared"}, 32'(irq_status), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 mux_sel", 32'(mux_sel), 0);
        chk("R11 mux_en", 32'(mux_en), 0);
        chk("R11 conv_req", 32'(conv_req), 0);
        chk("R11 busy", 32'(busy), 0);
        chk("R11 result", 32'(result), 0);
        chk("R11 irq_status", 32'(irq_status), 0);
        chk("R11 irq", 32'(irq), 0);

        // R10 write without start
        wr(2'd0, cword(1'b1, 10'h008, 4'd3, 1'b0));
        chk("R10 mux_sel", 32'(mux_sel), 3);
        chk("R10 mux_en", 32'(mux_en), 32'h008);
        repeat (SETTLE + 2) @(negedge clk);
        chk("R10 no req", 32'(conv_req), 0);
        chk("R10 no busy", 32'(busy), 0);
        chk("R10 no done", 32'(irq_status), 0);

        run_conv(1'b0, 10'h001, 4'd0, 16'h1234, 0, "ch0");
        run_conv(1'b1, 10'h020, 4'd5, 16'h8001, 2, "ch5 settle");
        run_conv(1'b0, 10'h100, 4'd8, 16'h7FFF, 1, "R12 ch8");
        run_conv(1'b1, 10'h200, 4'd9, 16'h0000, 3, "R12 ch9");

        // R8 control write while busy
        wr(2'd0, cword(1'b0, 10'h002, 4'd1, 1'b1));
        wr(2'd0, cword(1'b0, 10'h080, 4'd7, 1'b1));
        chk("R8 mux_sel kept", 32'(mux_sel), 1);
        chk("R8 mux_en kept", 32'(mux_en), 32'h002);
        conv_ready = 1'b1; conv_data = 16'hA5A5;
        @(negedge clk);
        conv_ready = 1'b0;
        chk("R8 result", 32'(result), 32'(offset_of(16'hA5A5)));
        repeat (4) @(negedge clk);
        chk("R8 no second req", 32'(conv_req), 0);
        chk("R8 idle", 32'(busy), 0);
        wr(2'd2, 16'h0004);

        // R9 disabled channel and out-of-range channel
        wr(2'd0, cword(1'b0, 10'h004, 4'd4, 1'b1));
        chk("R9 result zero", 32'(result), 0);
        chk("R9 no busy", 32'(busy), 0);
        chk("R9 no req", 32'(conv_req), 0);
        chk("R9 done", 32'(irq_status), 32'h0004);
        wr(2'd2, 16'h0004);
        run_conv(1'b0, 10'h001, 4'd0, 16'h4444, 0, "R9 refill");
        wr(2'd0, cword(1'b1, 10'h3FF, 4'd12, 1'b1));
        chk("R9 range result", 32'(result), 0);
        chk("R9 range busy", 32'(busy), 0);
        chk("R9 range done", 32'(irq_status), 32'h0004);

        // R7 masking and R6 write-zero
        chk("R7 masked", 32'(irq), 0);
        wr(2'd1, 16'h0004);
        chk("R7 enabled", 32'(irq), 1);
        wr(2'd2, 16'hFFFB);
        chk("R6 write zero keeps", 32'(irq_status), 32'h0004);
        wr(2'd2, 16'h0004);
        chk("R7 irq cleared", 32'(irq), 0);

        // R6 completion and clear on the same edge
        wr(2'd0, cword(1'b0, 10'h040, 4'd6, 1'b1));
        @(negedge clk);
        host_we = 1'b1; host_addr = 2'd2; host_wdata = 16'h0004;
        conv_ready = 1'b1; conv_data = 16'h0F0F;
        @(negedge clk);
        host_we = 1'b0; conv_ready = 1'b0;
        chk("R6 set wins", 32'(irq_status), 32'h0004);
        chk("R7 irq with enable", 32'(irq), 1);
        wr(2'd1, 16'h0000);
        chk("R7 mask off", 32'(irq), 0);
        wr(2'd2, 16'h0004);

        // random conversions
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 30; i++) begin
            logic [3:0]  ch;
            logic        st;
            logic [15:0] d;
            int          lat;
            ch  = 4'($urandom_range(0, 9));
            st  = 1'($urandom_range(0, 1));
            d   = 16'($urandom);
            lat = $urandom_range(0, 3);
            run_conv(st, 10'(1 << ch) | 10'($urandom & 32'h3FF), ch, d, lat, "random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule